// File: doc/BRIEF.md
# Looping Test Pattern Store

This block holds a short digital stimulus pattern and plays it back at full rate to drive a converter under test. It has two modes, chosen by one select input. In load mode, pattern bits come in one at a time on a slow serial path, each qualified by a strobe. They are packed into 8-bit words, and each finished word is stored at the next free address. In play mode, the stored words leave on an 8-bit parallel output, one word per clock. When the last word of the pattern has been sent, playback jumps straight back to the first word. A short pattern can therefore be repeated for as long as the test runs.

Storage holds 2048 bits, organised as 256 words of 8 bits. The pattern length is the number of complete words loaded since load mode was last entered. Software can override it with a length-write strobe while in load mode. The mode select is registered. The clock edge that first sees a new mode value is the entry edge: it resets the relevant address and discards any partly packed word. A strobe on the entry edge into load mode is not taken. The slow and fast clock domains are modelled as one clock.

Top module: `pattern_loop_mem`

## Requirements
- R1: After reset, pat_valid is 0 and pat_word is 0, and they stay so in play mode until a word has been loaded.
- R2: In load mode, each ser_strobe shifts ser_bit in, first bit into bit 7 (MSB first). The eighth strobe stores the packed word at the next address, starting at address 0.
- R3: The entry edge into load mode resets the write address, the stored-word count and the pattern length to 0. Until new words are loaded, play mode then gives no valid output.
- R4: By default, the pattern length equals the number of complete words loaded. Playback sends addresses 0 to length-1 in order, then wraps to 0 with no idle cycle.
- R5: If mode_read is first sampled high at edge E0, pat_valid stays 0 after E0. After E0+1 it is 1 with word 0, and one further word appears after each following edge.
- R6: In load mode, len_wr with len_val in 1..256 sets the pattern length. Values 0 and above 256 are ignored. When len_wr coincides with a word store, the written length wins.
- R7: ser_strobe and len_wr have no effect while mode_read is high; the output stream continues unchanged.
- R8: A partly packed word (fewer than 8 strobes) is discarded on a mode change and never stored.
- R9: pat_valid is 1 only in play mode with at least one word stored. pat_word is 0 whenever pat_valid is 0.
- R10: Once 256 words are stored, further strobes are ignored and the length stays 256.
- R11: After the edge that first samples mode_read low, pat_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_read | input | 1 | 1 = play mode, 0 = load mode |
| ser_bit | input | 1 | Serial pattern bit |
| ser_strobe | input | 1 | Qualifies ser_bit for one clock |
| len_wr | input | 1 | Length write strobe (load mode only) |
| len_val | input | 9 | Pattern length to write, 1..256 |
| pat_word | output | 8 | Replayed pattern word |
| pat_valid | output | 1 | pat_word holds a pattern word |

## Verification
Two functions can land on the same edge. The first is a word store on the eighth strobe, which would set the length to the word count. The second is a length write. The bench raises len_wr with a value of 1 on the same clock as the eighth strobe of the third word. It then checks that playback repeats only word 0, showing that the written length took priority. A second collision occurs in play mode, when the wrap from the last address coincides with serial strobes that must be ignored. The bench toggles ser_strobe throughout playback and compares every output word with the expected looped sequence.

// File: rtl/pattern_loop_pkg.sv
package pattern_loop_pkg;

  typedef enum logic [1:0] {
    PH_LOAD       = 2'd0,
    PH_ENTER_LOAD = 2'd1,
    PH_PLAY       = 2'd2,
    PH_ENTER_PLAY = 2'd3
  } phase_t;

  // Decode the requested mode against the registered mode.
  function automatic phase_t phase_of(input logic want_play, input logic was_play);
    phase_t p;
    unique case ({want_play, was_play})
      2'b00:   p = PH_LOAD;
      2'b01:   p = PH_ENTER_LOAD;
      2'b11:   p = PH_PLAY;
      default: p = PH_ENTER_PLAY;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/serial_packer.sv
module serial_packer #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              accept,
  input  logic              bit_in,
  output logic              commit,
  output logic [WORD_W-1:0] word_out
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  nbits;

  assign commit   = accept && !clear && (nbits == LAST);
  assign word_out = {shreg[WORD_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      shreg <= '0;
      nbits <= '0;
    end else if (accept) begin
      shreg <= {shreg[WORD_W-2:0], bit_in};
      nbits <= (nbits == LAST) ? '0 : nbits + 1'b1;
    end
  end

  // R8
  partial_drop_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (nbits == '0));

endmodule

// File: rtl/load_tracker.sv
module load_tracker #(
  parameter int DEPTH  = 256,
  parameter int LEN_W  = 9,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              commit,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_val,
  output logic [ADDR_W-1:0] waddr,
  output logic [LEN_W-1:0]  nwords,
  output logic [LEN_W-1:0]  plen,
  output logic              full
);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);

  logic len_ok;
  assign len_ok = len_wr && (len_val != '0) && (len_val <= DEPTH_L);
  assign full   = (nwords == DEPTH_L);
  assign waddr  = nwords[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      nwords <= '0;
    end else if (commit && !full) begin
      nwords <= nwords + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      plen <= '0;
    end else if (len_ok) begin
      plen <= len_val;
    end else if (commit && !full) begin
      plen <= nwords + 1'b1;
    end
  end

  // R10
  word_cap_chk: assert property (@(posedge clk) disable iff (rst)
    nwords <= DEPTH_L);

  // R3
  entry_reset_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (nwords == '0) && (plen == '0));

endmodule

// File: rtl/pattern_ram.sv
module pattern_ram #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/loop_addr_gen.sv
module loop_addr_gen #(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  input  logic [LEN_W-1:0]  plen,
  output logic [ADDR_W-1:0] raddr
);
  logic at_end;
  assign at_end = ({1'b0, raddr} == (plen - 1'b1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      raddr <= '0;
    end else if (adv) begin
      raddr <= at_end ? '0 : raddr + 1'b1;
    end
  end

  // R4
  addr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    adv |-> ({1'b0, raddr} < plen));

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && ({1'b0, raddr} == plen - 1'b1)) |=> (raddr == '0));

endmodule

// File: rtl/pattern_loop_mem.sv
module pattern_loop_mem
  import pattern_loop_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 256
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        mode_read,
  input  logic                        ser_bit,
  input  logic                        ser_strobe,
  input  logic                        len_wr,
  input  logic [$clog2(DEPTH):0]      len_val,
  output logic [WORD_W-1:0]           pat_word,
  output logic                        pat_valid
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LEN_W  = ADDR_W + 1;

  logic              mode_q;
  phase_t            phase;
  logic              in_load, in_play;
  logic              commit, full, rd_en;
  logic [WORD_W-1:0] packed_word, rdata;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [LEN_W-1:0]  nwords, plen;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= mode_read;
  end

  assign phase   = phase_of(mode_read, mode_q);
  assign in_load = (phase == PH_LOAD);
  assign in_play = (phase == PH_PLAY);
  assign rd_en   = in_play && (plen != '0) && (nwords != '0);

  serial_packer #(.WORD_W(WORD_W)) u_packer (
    .clk      (clk),
    .rst      (rst),
    .clear    (!in_load),
    .accept   (ser_strobe && in_load && !full),
    .bit_in   (ser_bit),
    .commit   (commit),
    .word_out (packed_word)
  );

  load_tracker #(.DEPTH(DEPTH), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_track (
    .clk     (clk),
    .rst     (rst),
    .clr     (phase == PH_ENTER_LOAD),
    .commit  (commit),
    .len_wr  (len_wr && in_load),
    .len_val (len_val),
    .waddr   (waddr),
    .nwords  (nwords),
    .plen    (plen),
    .full    (full)
  );

  pattern_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (commit && !full),
    .waddr (waddr),
    .wdata (packed_word),
    .re    (rd_en),
    .raddr (raddr),
    .rdata (rdata)
  );

  loop_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
    .clk   (clk),
    .rst   (rst),
    .clr   (phase == PH_ENTER_PLAY),
    .adv   (rd_en),
    .plen  (plen),
    .raddr (raddr)
  );

  always_ff @(posedge clk) begin
    if (rst) pat_valid <= 1'b0;
    else     pat_valid <= rd_en;
  end

  assign pat_word = pat_valid ? rdata : '0;

  // R9
  valid_in_play_chk: assert property (@(posedge clk) disable iff (rst)
    pat_valid |-> mode_q);

  // R9
  valid_needs_words_chk: assert property (@(posedge clk) disable iff (rst)
    pat_valid |-> (nwords != '0));

  // R11
  exit_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !mode_read) |=> !pat_valid);

endmodule

// File: tb/pattern_loop_mem_bench.sv
module pattern_loop_mem_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       mode_read, ser_bit, ser_strobe, len_wr;
  logic [8:0] len_val;
  logic [7:0] pat_word;
  logic       pat_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pattern_loop_mem u_pattern_loop_mem (
    .clk(clk), .rst(rst), .mode_read(mode_read), .ser_bit(ser_bit),
    .ser_strobe(ser_strobe), .len_wr(len_wr), .len_val(len_val),
    .pat_word(pat_word), .pat_valid(pat_valid)
  );

  // {word count, length override (0 = none), seed}
  localparam logic [25:0] VEC [6] = '{
    {9'd1, 9'd0, 8'hA5},
    {9'd3, 9'd0, 8'h3C},
    {9'd5, 9'd2, 8'hF0},
    {9'd4, 9'd0, 8'h00},
    {9'd7, 9'd7, 8'h81},
    {9'd2, 9'd0, 8'hFF}
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed ^ 8'(i * 37);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic enter_load();
    mode_read = 1'b0;
    step();
  endtask

  task automatic put_word(input logic [7:0] w, input bit with_len, input int lv);
    for (int b = 7; b >= 0; b--) begin
      ser_bit    = w[b];
      ser_strobe = 1'b1;
      if (b == 0 && with_len) begin
        len_wr  = 1'b1;
        len_val = 9'(lv);
      end
      step();
    end
    ser_strobe = 1'b0;
    len_wr     = 1'b0;
  endtask

  task automatic put_len(input int lv);
    len_wr  = 1'b1;
    len_val = 9'(lv);
    step();
    len_wr  = 1'b0;
  endtask

  // Enter play mode and check n_out words of a loop of length L.
  task automatic play(input logic [7:0] seed, input int L, input int n_out,
                      input bit noisy, input string req);
    mode_read = 1'b1;
    step();
    check({req, "/R5 entry edge valid"}, pat_valid, 0);
    for (int k = 0; k < n_out; k++) begin
      if (noisy) begin
        ser_strobe = k[0];
        ser_bit    = k[1];
        len_wr     = k[0];
        len_val    = 9'd1;
      end
      step();
      check({req, " valid"}, pat_valid, 1);
      check({req, " word"}, pat_word, pat(seed, k % L));
    end
    ser_strobe = 1'b0;
    len_wr     = 1'b0;
  endtask

  initial begin
    rst = 1'b1; mode_read = 1'b0; ser_bit = 1'b0; ser_strobe = 1'b0;
    len_wr = 1'b0; len_val = '0;
    step(); step();
    rst = 1'b0;
    // R1: reset state and empty play
    check("R1 reset valid", pat_valid, 0);
    check("R1 reset word", pat_word, 0);
    mode_read = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R1/R9 empty play valid", pat_valid, 0);
      check("R1 empty play word", pat_word, 0);
    end

    // Vector table: R2, R4, R5, R6
    for (int v = 0; v < 6; v++) begin
      int n, lp, L;
      logic [7:0] sd;
      n  = int'(VEC[v][25:17]);
      lp = int'(VEC[v][16:8]);
      sd = VEC[v][7:0];
      enter_load();
      for (int i = 0; i < n; i++) put_word(pat(sd, i), 1'b0, 0);
      if (lp != 0) put_len(lp);
      L = (lp != 0) ? lp : n;
      play(sd, L, 2 * L + 3, 1'b0, "R2/R4/R6 table");
    end

    // R11: leaving play mode drops valid
    mode_read = 1'b0;
    step();
    check("R11 exit valid", pat_valid, 0);
    check("R9 exit word", pat_word, 0);

    // R3: re-entering load mode empties the pattern
    mode_read = 1'b1;
    step(); step(); step();
    check("R3 empty after reload valid", pat_valid, 0);
    // (previous loop was left in load mode then play: entering load resets)
    enter_load();
    mode_read = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R3 no words after entry", pat_valid, 0);
    end

    // R8: partial word discarded
    enter_load();
    put_word(pat(8'h5A, 0), 1'b0, 0);
    put_word(pat(8'h5A, 1), 1'b0, 0);
    for (int b = 0; b < 5; b++) begin
      ser_bit = 1'b1; ser_strobe = 1'b1; step();
    end
    ser_strobe = 1'b0;
    play(8'h5A, 2, 7, 1'b0, "R8 partial dropped");

    // R7: strobes and length writes in play mode ignored
    mode_read = 1'b0; step();
    enter_load();
    for (int i = 0; i < 3; i++) put_word(pat(8'h17, i), 1'b0, 0);
    play(8'h17, 3, 12, 1'b1, "R7 play ignores load");

    // R6: invalid lengths ignored, collision with store
    mode_read = 1'b0; step();
    enter_load();
    for (int i = 0; i < 3; i++) put_word(pat(8'h66, i), 1'b0, 0);
    put_len(0);
    put_len(300);
    play(8'h66, 3, 8, 1'b0, "R6 bad length ignored");
    mode_read = 1'b0; step();
    enter_load();
    put_word(pat(8'h42, 0), 1'b0, 0);
    put_word(pat(8'h42, 1), 1'b0, 0);
    put_word(pat(8'h42, 2), 1'b1, 1);
    play(8'h42, 1, 5, 1'b0, "R6 length write wins");

    // R10: full capacity and overflow strobes ignored
    mode_read = 1'b0; step();
    enter_load();
    for (int i = 0; i < 256; i++) put_word(pat(8'hC3, i), 1'b0, 0);
    put_word(8'h00, 1'b0, 0);
    play(8'hC3, 256, 260, 1'b0, "R10 full");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule